// File: doc/BRIEF.md
# Protected System-Bus DMA Channel Controller

This block is the control side of a single DMA channel that moves data between system memory and an expansion-bus region. Software programs source and destination addresses, a length, a direction and an enable bit through a small register port, then writes the start register. Before any data moves, the block validates the request. The source must lie in a system-memory region. The destination must lie in an expansion region. The whole source span must also fit inside a window set by a protection register, and that register only accepts writes that carry a key.

A request that fails validation is dropped. The channel disarms and raises one of two error pulses: one for a bad region and one for a span outside the window. A request that passes holds the channel busy for a time proportional to the length. That busy period stands in for the data movement. While busy, the block presents the effective source and destination addresses to the datapath, with their roles swapped if the direction bit asks for it. When the busy period ends, the block advances both address registers and clears the length. It re-arms or disarms the channel according to the top length bit and pulses a completion interrupt. Reads from the register port are combinational.

Top module: `sbdma_channel`

## Requirements
- R1: After reset every register reads 0 except the suspend register, which reads 0x10. The busy output, the three interrupt outputs and the datapath address outputs are all 0.
- R2: A write to the source register (index 0) or the destination register (index 1) stores the write data ANDed with 0x1FFFFFE0.
- R3: A write to the protection register (index 7) takes effect only if data[31:16] is 0x4659. It then stores data[14:0] & 0x7F7F. Any other write leaves the register unchanged.
- R4: A write to the start register (index 5) launches a request only if data bit 0 is 1, the enable register (index 4, bit 0) already holds 1, and the channel is idle. Otherwise the write changes nothing.
- R5: A request is illegal if source bits 28:26 are neither 1 nor 3, or destination bits 28:26 are neither 0 nor 5. An illegal request clears enable, does not go busy, and pulses irq_illegal high for exactly the one cycle after the start write.
- R6: Let bottom = (prot[14:8] << 20) | 0x08000000 and top = (prot[6:0] << 20) | 0x080FFFE0. A request with legal regions is an overrun unless both the source and source + len[30:0] − 1 lie within bottom..top inclusive. An overrun clears enable, does not go busy, and pulses irq_overrun for one cycle.
- R7: A valid request makes the channel busy for max(1, len[30:0] >> 1) cycles, starting the cycle after the start write. While busy, the start register reads 1 and suspend bit 4 reads 0.
- R8: While busy, mv_src and mv_dst carry the source and destination registers when the direction register (index 3, bit 0) is 0, and the two values swapped when it is 1. When idle, both outputs are 0.
- R9: In the cycle after the busy period ends, the source and destination registers have each advanced by len[30:0]. The length register (index 2) reads 0, suspend bit 4 reads 1, and irq_done is high for exactly that cycle. Software writes to the suspend register (index 6) store every bit except bit 4, which only the hardware changes.
- R10: On completion, enable becomes 0 if length bit 31 was 1, and becomes 1 otherwise.
- R11: Register indices: 0 source, 1 destination, 2 length, 3 direction, 4 enable, 5 start, 6 suspend, 7 protection. rd_data shows the addressed register in the same cycle, with 1-bit registers in bit 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_en | input | 1 | Register write strobe |
| wr_idx | input | 3 | Register index for the write |
| wr_data | input | 32 | Write data |
| rd_idx | input | 3 | Register index for the read |
| rd_data | output | 32 | Read data, combinational |
| mv_busy | output | 1 | Transfer in progress |
| mv_src | output | 32 | Effective source address for the datapath |
| mv_dst | output | 32 | Effective destination address for the datapath |
| irq_done | output | 1 | Completion pulse |
| irq_illegal | output | 1 | Illegal-region pulse |
| irq_overrun | output | 1 | Protection-window overrun pulse |

## Verification
The assertions assume one register write per cycle and a reset that is held until the clock runs. Under those conditions a completion can never coincide with an accepted start, because a start is only accepted when the channel is idle. The bench keeps to this by driving each write for a single cycle at the falling edge. It leaves idle cycles between a start and the end of its busy period, and it never writes the registers that completion updates in the same cycle as completion. This is why the one-hot interrupt and single-pulse properties are valid stimulus constraints rather than gaps.

// File: rtl/sbdma_pkg.sv
package sbdma_pkg;
  localparam int DW    = 32;
  localparam int IDX_W = 3;
  localparam int PW    = 15;
  localparam int CNT_W = DW - 1;

  typedef enum logic [IDX_W-1:0] {
    RG_SRC  = 3'd0,
    RG_DST  = 3'd1,
    RG_LEN  = 3'd2,
    RG_DIR  = 3'd3,
    RG_EN   = 3'd4,
    RG_GO   = 3'd5,
    RG_SUSP = 3'd6,
    RG_PROT = 3'd7
  } reg_idx_e;

  localparam logic [DW-1:0] ADDR_MASK = 32'h1FFF_FFE0;
  localparam logic [15:0]   PROT_KEY  = 16'h4659;
  localparam logic [PW-1:0] PROT_MASK = 15'h7F7F;
  localparam logic [DW-1:0] WIN_LO    = 32'h0800_0000;
  localparam logic [DW-1:0] WIN_HI    = 32'h080F_FFE0;
  localparam int            IDLE_BIT  = 4;
  localparam logic [DW-1:0] SUSP_RST  = 32'h0000_0010;

  function automatic logic src_region_ok(input logic [DW-1:0] a);
    return (a[28:26] == 3'd1) || (a[28:26] == 3'd3);
  endfunction

  function automatic logic dst_region_ok(input logic [DW-1:0] a);
    return (a[28:26] == 3'd0) || (a[28:26] == 3'd5);
  endfunction
endpackage

// File: rtl/sbdma_check.sv
module sbdma_check
  import sbdma_pkg::*;
(
  input  logic [DW-1:0] src,
  input  logic [DW-1:0] dst,
  input  logic [DW-1:0] len,
  input  logic [PW-1:0] prot,
  output logic          bad_region,
  output logic          out_of_window
);
  logic [DW-1:0] lo_bound, hi_bound, last_byte;
  logic          first_in, last_in;

  always_comb begin
    lo_bound      = {5'd0, prot[14:8], 20'd0} | WIN_LO;
    hi_bound      = {5'd0, prot[6:0], 20'd0} | WIN_HI;
    last_byte     = src + {1'b0, len[DW-2:0]} - 32'd1;
    first_in      = (src >= lo_bound) && (src <= hi_bound);
    last_in       = (last_byte >= lo_bound) && (last_byte <= hi_bound);
    bad_region    = !src_region_ok(src) || !dst_region_ok(dst);
    out_of_window = !bad_region && !(first_in && last_in);
  end
endmodule

// File: rtl/sbdma_timer.sv
module sbdma_timer
  import sbdma_pkg::*;
#(
  parameter int CW = CNT_W
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          load,
  input  logic [CW-1:0] units,
  output logic          busy,
  output logic          run_end
);
  logic [CW-1:0] cnt_q, cnt_d;
  logic          busy_q, busy_d;

  always_comb begin
    cnt_d  = cnt_q;
    busy_d = busy_q;
    if (load) begin
      busy_d = 1'b1;
      cnt_d  = (units == '0) ? CW'(1) : units;
    end else if (busy_q) begin
      if (cnt_q == CW'(1)) busy_d = 1'b0;
      else                 cnt_d  = cnt_q - CW'(1);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q  <= '0;
      busy_q <= 1'b0;
    end else begin
      cnt_q  <= cnt_d;
      busy_q <= busy_d;
    end
  end

  assign busy    = busy_q;
  assign run_end = busy_q && (cnt_q == CW'(1));

  p_cnt_live_r7: assert property (@(posedge clk) disable iff (!rst_n)
    busy_q |-> (cnt_q != '0));
  p_no_reload_r4: assert property (@(posedge clk) disable iff (!rst_n)
    busy_q |-> !load);
endmodule

// File: rtl/sbdma_channel.sv
module sbdma_channel
  import sbdma_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [IDX_W-1:0]  wr_idx,
  input  logic [DW-1:0]     wr_data,
  input  logic [IDX_W-1:0]  rd_idx,
  output logic [DW-1:0]     rd_data,
  output logic              mv_busy,
  output logic [DW-1:0]     mv_src,
  output logic [DW-1:0]     mv_dst,
  output logic              irq_done,
  output logic              irq_illegal,
  output logic              irq_overrun
);
  logic [DW-1:0] src_q, src_d, dst_q, dst_d, len_q, len_d, susp_q, susp_d;
  logic [PW-1:0] prot_q, prot_d;
  logic          dir_q, dir_d, en_q, en_d;
  logic          done_q, done_d, ill_q, ill_d, ovr_q, ovr_d;
  logic          busy, run_end, bad_region, out_of_window, go_req, launch;
  logic [DW-2:0] span;

  assign span = len_q[DW-2:0];

  sbdma_check u_check (
    .src           (src_q),
    .dst           (dst_q),
    .len           (len_q),
    .prot          (prot_q),
    .bad_region    (bad_region),
    .out_of_window (out_of_window)
  );

  assign go_req = wr_en && (reg_idx_e'(wr_idx) == RG_GO) && wr_data[0] && en_q && !busy;
  assign launch = go_req && !bad_region && !out_of_window;

  sbdma_timer #(.CW(CNT_W)) u_timer (
    .clk     (clk),
    .rst_n   (rst_n),
    .load    (launch),
    .units   ({1'b0, span[DW-2:1]}),
    .busy    (busy),
    .run_end (run_end)
  );

  always_comb begin
    src_d  = src_q;  dst_d = dst_q;  len_d = len_q;  susp_d = susp_q;
    prot_d = prot_q; dir_d = dir_q;  en_d  = en_q;
    done_d = 1'b0;   ill_d = 1'b0;   ovr_d = 1'b0;
    if (run_end) begin
      src_d            = src_q + {1'b0, span};
      dst_d            = dst_q + {1'b0, span};
      len_d            = '0;
      en_d             = ~len_q[DW-1];
      susp_d[IDLE_BIT] = 1'b1;
      done_d           = 1'b1;
    end
    if (wr_en) begin
      case (reg_idx_e'(wr_idx))
        RG_SRC:  src_d = wr_data & ADDR_MASK;
        RG_DST:  dst_d = wr_data & ADDR_MASK;
        RG_LEN:  len_d = wr_data;
        RG_DIR:  dir_d = wr_data[0];
        RG_EN:   en_d  = wr_data[0];
        RG_GO: begin
          if (go_req) begin
            if (bad_region) begin
              en_d  = 1'b0;
              ill_d = 1'b1;
            end else if (out_of_window) begin
              en_d  = 1'b0;
              ovr_d = 1'b1;
            end else begin
              susp_d[IDLE_BIT] = 1'b0;
            end
          end
        end
        RG_SUSP: susp_d = {wr_data[DW-1:IDLE_BIT+1], susp_q[IDLE_BIT], wr_data[IDLE_BIT-1:0]};
        RG_PROT: if (wr_data[31:16] == PROT_KEY) prot_d = wr_data[PW-1:0] & PROT_MASK;
        default: ;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      src_q  <= '0;  dst_q <= '0;  len_q <= '0;  susp_q <= SUSP_RST;
      prot_q <= '0;  dir_q <= 1'b0; en_q <= 1'b0;
      done_q <= 1'b0; ill_q <= 1'b0; ovr_q <= 1'b0;
    end else begin
      src_q  <= src_d;  dst_q <= dst_d;  len_q <= len_d;  susp_q <= susp_d;
      prot_q <= prot_d; dir_q <= dir_d;  en_q  <= en_d;
      done_q <= done_d; ill_q <= ill_d;  ovr_q <= ovr_d;
    end
  end

  always_comb begin
    case (reg_idx_e'(rd_idx))
      RG_SRC:  rd_data = src_q;
      RG_DST:  rd_data = dst_q;
      RG_LEN:  rd_data = len_q;
      RG_DIR:  rd_data = {{(DW-1){1'b0}}, dir_q};
      RG_EN:   rd_data = {{(DW-1){1'b0}}, en_q};
      RG_GO:   rd_data = {{(DW-1){1'b0}}, busy};
      RG_SUSP: rd_data = susp_q;
      RG_PROT: rd_data = {{(DW-PW){1'b0}}, prot_q};
      default: rd_data = '0;
    endcase
  end

  assign mv_busy     = busy;
  assign mv_src      = busy ? (dir_q ? dst_q : src_q) : '0;
  assign mv_dst      = busy ? (dir_q ? src_q : dst_q) : '0;
  assign irq_done    = done_q;
  assign irq_illegal = ill_q;
  assign irq_overrun = ovr_q;

  p_go_gated_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && wr_idx == 3'd5 && !en_q && !busy) |=> !busy);
  p_busy_susp_r7: assert property (@(posedge clk) disable iff (!rst_n)
    busy |-> !susp_q[IDLE_BIT]);
  p_err_disarms_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (irq_illegal || irq_overrun) |-> !en_q);
  p_done_on_end_r9: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(busy) |-> irq_done);
  p_done_single_r9: assert property (@(posedge clk) disable iff (!rst_n)
    irq_done |=> !irq_done);
  p_one_irq_r6: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({irq_done, irq_illegal, irq_overrun}));
endmodule

// File: tb/test_sbdma_channel.sv
module test_sbdma_channel;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        wr_en = 1'b0;
  logic [2:0]  wr_idx = '0;
  logic [31:0] wr_data = '0;
  logic [2:0]  rd_idx = '0;
  logic [31:0] rd_data, mv_src, mv_dst;
  logic        mv_busy, irq_done, irq_illegal, irq_overrun;

  int checks = 0;
  int errors = 0;
  bit armed = 0;

  always #2 clk = ~clk;

  sbdma_channel i_sbdma_channel (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_idx(wr_idx), .wr_data(wr_data),
    .rd_idx(rd_idx), .rd_data(rd_data), .mv_busy(mv_busy), .mv_src(mv_src),
    .mv_dst(mv_dst), .irq_done(irq_done), .irq_illegal(irq_illegal),
    .irq_overrun(irq_overrun)
  );

  // Reference model (R11 index map: 0 src,1 dst,2 len,3 dir,4 en,5 start,6 susp,7 prot)
  logic [31:0] m_src, m_dst, m_len, m_susp;
  logic [14:0] m_prot;
  logic        m_dir, m_en, m_busy, m_done, m_ill, m_ovr;
  longint      m_cnt;

  always @(posedge clk) begin
    if (!rst_n) begin
      m_src = 0; m_dst = 0; m_len = 0; m_susp = 32'h10; m_prot = 0;
      m_dir = 0; m_en = 0; m_busy = 0; m_cnt = 0;
      m_done = 0; m_ill = 0; m_ovr = 0;
      armed = 1;
    end else begin
      logic [31:0] o_src, o_dst, o_len, last;
      logic [14:0] o_prot;
      logic        o_en, o_busy, rok;
      longint      lo, hi, u;
      o_src = m_src; o_dst = m_dst; o_len = m_len; o_prot = m_prot;
      o_en = m_en; o_busy = m_busy;
      m_done = 0; m_ill = 0; m_ovr = 0;
      if (m_busy) begin
        if (m_cnt == 1) begin
          m_src = m_src + {1'b0, m_len[30:0]};
          m_dst = m_dst + {1'b0, m_len[30:0]};
          m_en = !m_len[31];
          m_len = 0; m_susp[4] = 1; m_done = 1; m_busy = 0;
        end else m_cnt = m_cnt - 1;
      end
      if (wr_en) begin
        case (wr_idx)
          3'd0: m_src = wr_data & 32'h1FFFFFE0;
          3'd1: m_dst = wr_data & 32'h1FFFFFE0;
          3'd2: m_len = wr_data;
          3'd3: m_dir = wr_data[0];
          3'd4: m_en = wr_data[0];
          3'd5: if (wr_data[0] && o_en && !o_busy) begin
            rok = ((o_src >> 26) % 8 == 1 || (o_src >> 26) % 8 == 3) &&
                  ((o_dst >> 26) % 8 == 0 || (o_dst >> 26) % 8 == 5);
            lo = longint'((o_prot >> 8) % 128) * 1048576 + 64'h0800_0000;
            hi = longint'(o_prot % 128) * 1048576 + 64'h080F_FFE0;
            last = o_src + {1'b0, o_len[30:0]} - 1;
            if (!rok) begin m_en = 0; m_ill = 1; end
            else if (!(o_src >= lo && o_src <= hi && last >= lo && last <= hi)) begin
              m_en = 0; m_ovr = 1;
            end else begin
              u = longint'(o_len[30:0]) / 2;
              m_busy = 1; m_cnt = (u == 0) ? 1 : u; m_susp[4] = 0;
            end
          end
          3'd6: m_susp = {wr_data[31:5], m_susp[4], wr_data[3:0]};
          default: if (wr_data[31:16] == 16'h4659) m_prot = wr_data[14:0] & 15'h7F7F;
        endcase
      end
    end
  end

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual=%h expected=%h at %0t", tag, act, exp, $time);
    end
  endtask

  function automatic logic [31:0] m_read(input logic [2:0] i);
    case (i)
      3'd0: return m_src;
      3'd1: return m_dst;
      3'd2: return m_len;
      3'd3: return {31'd0, m_dir};
      3'd4: return {31'd0, m_en};
      3'd5: return {31'd0, m_busy};
      3'd6: return m_susp;
      default: return {17'd0, m_prot};
    endcase
  endfunction

  function automatic string rd_tag(input logic [2:0] i);
    case (i)
      3'd0, 3'd1: return "R2 read src/dst";
      3'd2:       return "R9 read len";
      3'd3:       return "R8 read dir";
      3'd4:       return "R10 read enable";
      3'd5:       return "R7 read start";
      3'd6:       return "R9 read suspend";
      default:    return "R3 read prot";
    endcase
  endfunction

  // Compare against the model on every cycle, away from the active edge
  always @(negedge clk) begin
    if (armed && rst_n) begin
      chk("R9 irq_done", {31'd0, irq_done}, {31'd0, m_done});
      chk("R5 irq_illegal", {31'd0, irq_illegal}, {31'd0, m_ill});
      chk("R6 irq_overrun", {31'd0, irq_overrun}, {31'd0, m_ovr});
      chk("R7 mv_busy", {31'd0, mv_busy}, {31'd0, m_busy});
      chk("R8 mv_src", mv_src, m_busy ? (m_dir ? m_dst : m_src) : 32'd0);
      chk("R8 mv_dst", mv_dst, m_busy ? (m_dir ? m_src : m_dst) : 32'd0);
      chk(rd_tag(rd_idx), rd_data, m_read(rd_idx));
    end
  end

  task automatic wr(input logic [2:0] i, input logic [31:0] d);
    @(negedge clk);
    wr_en = 1; wr_idx = i; wr_data = d;
    @(negedge clk);
    wr_en = 0;
  endtask

  task automatic sweep();
    for (int i = 0; i < 8; i++) begin
      @(negedge clk);
      rd_idx = 3'(i);
    end
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  task automatic finish_run();
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    checks++; errors++;
    $display("FAIL watchdog: actual=timeout expected=finish");
    finish_run();
  end

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    // R1: reset state at the ports
    chk("R1 busy", {31'd0, mv_busy}, 32'd0);
    chk("R1 irqs", {29'd0, irq_done, irq_illegal, irq_overrun}, 32'd0);
    rd_idx = 3'd6;
    #0 chk("R1 suspend", rd_data, 32'h10);
    sweep();
    // R2 masking, R3 key
    wr(3'd0, 32'hFFFF_FFFF);
    wr(3'd1, 32'hFFFF_FFFF);
    wr(3'd7, 32'h1234_4050);
    wr(3'd6, 32'hFFFF_FFEF);
    sweep();
    wr(3'd7, 32'h4659_FFFF);
    wr(3'd7, 32'h4659_4050);
    // R4: start with enable clear does nothing
    wr(3'd0, 32'h0C00_0100);
    wr(3'd1, 32'h0070_0000);
    wr(3'd2, 32'h0000_0010);
    wr(3'd5, 32'h1);
    chk("R4 no launch without enable", {31'd0, mv_busy}, 32'd0);
    sweep();
    // normal run, re-arm (R10), start bit 0 clear ignored
    wr(3'd4, 32'h1);
    wr(3'd5, 32'h2);
    chk("R4 bit0 clear ignored", {31'd0, mv_busy}, 32'd0);
    rd_idx = 3'd5;
    wr(3'd5, 32'h1);
    idle(3);
    wr(3'd5, 32'h1);  // R4: ignored while busy
    idle(8);
    sweep();
    // run with length bit 31 set: disarm afterwards
    wr(3'd2, 32'h8000_0008);
    wr(3'd5, 32'h1);
    idle(6);
    sweep();
    // zero length: one busy cycle
    wr(3'd4, 32'h1);
    wr(3'd2, 32'h0);
    wr(3'd5, 32'h1);
    idle(3);
    // direction swap R8
    wr(3'd4, 32'h1);
    wr(3'd3, 32'h1);
    wr(3'd0, 32'h0C00_0400);
    wr(3'd1, 32'h1400_0000);
    wr(3'd2, 32'h0000_000C);
    wr(3'd5, 32'h1);
    idle(9);
    sweep();
    // R5 illegal source, illegal destination
    wr(3'd4, 32'h1);
    wr(3'd0, 32'h0010_0000);
    wr(3'd5, 32'h1);
    idle(2);
    wr(3'd4, 32'h1);
    wr(3'd0, 32'h0C00_0000);
    wr(3'd1, 32'h0800_0000);
    wr(3'd5, 32'h1);
    idle(2);
    sweep();
    // R6 overrun: tail past top, then head below bottom
    wr(3'd4, 32'h1);
    wr(3'd1, 32'h0000_0000);
    wr(3'd0, 32'h0D0F_FFC0);
    wr(3'd2, 32'h0000_0040);
    wr(3'd5, 32'h1);
    idle(2);
    wr(3'd4, 32'h1);
    wr(3'd7, 32'h4659_4850);
    wr(3'd0, 32'h0C00_0000);
    wr(3'd2, 32'h0000_0004);
    wr(3'd5, 32'h1);
    idle(2);
    // exact fit at the top edge is accepted
    wr(3'd4, 32'h1);
    wr(3'd7, 32'h4659_4050);
    wr(3'd0, 32'h0D0F_FFC0);
    wr(3'd2, 32'h0000_0021);
    wr(3'd5, 32'h1);
    idle(20);
    sweep();
    finish_run();
  end
endmodule